// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Status Flags

This block is a single-clock FIFO of parameterised depth. The flag behaviour is chosen while reset is held, and it keeps that choice until the next reset. In standard mode the read data register loads only when a read is accepted. The FIFO then reports a full flag and an empty flag, both active low. In first-word-fall-through (FWFT) mode the oldest stored word moves into the output register without a read request. That register counts as one more storage place, so the capacity is DEPTH+1. An input-ready flag (low means room) replaces the full flag. An output-ready flag (low means a word is presented) replaces the empty flag.

Besides these, the block has four more outputs. The almost-full flag and the almost-empty flag follow two offsets supplied from outside. The half-full flag marks a fill level above half the depth. The echo read-enable output pulses low after each accepted read. All flags are registered, and any request that its flag blocks leaves the contents and the output unchanged.

Top module: `ffq_dualmode_fifo`

## Requirements
- R1: The mode input is sampled while rst_n is low: 0 selects standard mode, 1 selects FWFT mode. After reset: full_flag=1 (std) or 0 (FWFT); empty_flag=0 (std) or 1 (FWFT); almost_full_n=1; almost_empty_n=0; half_full_n=1; echo_rd_n=1.
- R2: Standard mode: full_flag goes low on the edge that stores the DEPTH-th word when there are no reads. While full_flag is low, writes are ignored.
- R3: Standard mode: empty_flag is low exactly when nothing is stored, and reads are ignored while it is low. rd_data takes the oldest word on the edge that accepts a read.
- R4: FWFT mode: full_flag (input-ready) goes high once DEPTH+1 words are held, output register included, and writes are ignored while it is high.
- R5: FWFT mode: the first word written to an empty FIFO appears on rd_data on the second rising edge after its write. empty_flag goes low on that same edge, with no read request.
- R6: FWFT mode: empty_flag returns high only on a true read (rd_n=0, rd_sel_n=0, empty_flag=0) when no further word is stored. rd_data keeps the last word, and further reads are ignored.
- R7: almost_full_n is low when the level is at least C−m, where C is DEPTH (std) or DEPTH+1 (FWFT) and m is af_ofs.
- R8: almost_empty_n is low when the level is at most n (std) or n+1 (FWFT), where n is ae_ofs.
- R9: half_full_n is low when the level exceeds DEPTH/2 (std) or DEPTH/2+1 (FWFT).
- R10: echo_rd_n is low for the cycle after each edge at which a read was accepted, and high otherwise.
- R11: A read is accepted only when both rd_n and rd_sel_n are low. rd_sel_n has no effect on any flag, and in FWFT mode a word still falls through to the output register while rd_sel_n is high.
- R12: Words leave in the order they were written, with no loss or duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fwft_sel | input | 1 | Flag mode, sampled during reset (1 = FWFT) |
| wr_n | input | 1 | Write request, active low |
| wr_data | input | WIDTH | Write data |
| rd_n | input | 1 | Read request, active low |
| rd_sel_n | input | 1 | Read select, active low |
| af_ofs | input | LW | Almost-full offset m |
| ae_ofs | input | LW | Almost-empty offset n |
| rd_data | output | WIDTH | Output register |
| full_flag | output | 1 | Full (std, low = full) or input-ready (FWFT, high = no room) |
| empty_flag | output | 1 | Empty (std, low = empty) or output-ready (FWFT, low = word presented) |
| almost_full_n | output | 1 | Almost-full, active low |
| almost_empty_n | output | 1 | Almost-empty, active low |
| half_full_n | output | 1 | Half-full, active low |
| echo_rd_n | output | 1 | Echo of an accepted read, active low |

## Verification
Every flag, the echo output and a standard-mode read word are due one clock after the rising edge that caused them. A word written into an empty FIFO in FWFT mode reaches rd_data and output-ready on the second edge after its write. The bench drives its inputs at the falling edge and advances its queue model at each rising edge. It then compares all outputs at the next falling edge, so each result is taken in the cycle it first becomes due.

// File: rtl/ffq_pkg.sv
`timescale 1ns/1ps
package ffq_pkg;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} flag_mode_e;

  // level has reached the almost-full threshold (capacity minus offset)
  function automatic logic af_hit(input int lvl, input int m, input int cap);
    return (lvl + m) >= cap;
  endfunction

  // level at or under the almost-empty threshold; FWFT adds one
  function automatic logic ae_hit(input int lvl, input int n, input int fw);
    return lvl <= (n + fw);
  endfunction

  // level strictly above half the memory depth; FWFT adds one
  function automatic logic hf_hit(input int lvl, input int depth, input int fw);
    return lvl > ((depth / 2) + fw);
  endfunction
endpackage

// File: rtl/ffq_store.sv
`timescale 1ns/1ps
module ffq_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rptr];
endmodule

// File: rtl/ffq_outreg.sv
`timescale 1ns/1ps
module ffq_outreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fw,
  input  logic             pop,
  input  logic             rd_ok,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             valid,
  output logic             valid_next
);
  // in FWFT the register holds a word until a true read empties it
  assign valid_next = fw & (pop | (valid & ~rd_ok));

  always_ff @(posedge clk) begin
    if (pop) dout <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_next;
  end
endmodule

// File: rtl/ffq_flags.sv
`timescale 1ns/1ps
module ffq_flags
  import ffq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft_sel,
  input  logic          fw,
  input  logic [LW-1:0] lvl_next,
  input  logic [LW-1:0] af_ofs,
  input  logic [LW-1:0] ae_ofs,
  input  logic          rd_ok,
  input  logic          valid_next,
  output logic          full_flag,
  output logic          empty_flag,
  output logic          almost_full_n,
  output logic          almost_empty_n,
  output logic          half_full_n,
  output logic          echo_rd_n
);
  int lv, fwi, cap;

  always_comb begin
    lv  = int'(lvl_next);
    fwi = fw ? 1 : 0;
    cap = DEPTH + fwi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_flag      <= ~fwft_sel;
      empty_flag     <= fwft_sel;
      almost_full_n  <= 1'b1;
      almost_empty_n <= 1'b0;
      half_full_n    <= 1'b1;
      echo_rd_n      <= 1'b1;
    end else begin
      full_flag      <= fw ? (lv == cap) : (lv != DEPTH);
      empty_flag     <= fw ? ~valid_next : (lv != 0);
      almost_full_n  <= ~af_hit(lv, int'(af_ofs), cap);
      almost_empty_n <= ~ae_hit(lv, int'(ae_ofs), fwi);
      half_full_n    <= ~hf_hit(lv, DEPTH, fwi);
      echo_rd_n      <= ~rd_ok;
    end
  end
endmodule

// File: rtl/ffq_dualmode_fifo.sv
`timescale 1ns/1ps
module ffq_dualmode_fifo
  import ffq_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 2),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fwft_sel,
  input  logic             wr_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_n,
  input  logic             rd_sel_n,
  input  logic [LW-1:0]    af_ofs,
  input  logic [LW-1:0]    ae_ofs,
  output logic [WIDTH-1:0] rd_data,
  output logic             full_flag,
  output logic             empty_flag,
  output logic             almost_full_n,
  output logic             almost_empty_n,
  output logic             half_full_n,
  output logic             echo_rd_n
);
  flag_mode_e       mode_q;
  logic             fw;
  logic             wr_ok, rd_ok, push, pop;
  logic [CW-1:0]    mcount;
  logic [WIDTH-1:0] mem_word;
  logic             valid, valid_next;
  logic [LW-1:0]    lvl_next, lvl_now;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= flag_mode_e'(fwft_sel);
  end

  assign fw = (mode_q == MODE_FWFT);

  // full_flag/empty_flag polarities swap between modes; the permit is a mismatch with fw
  assign wr_ok = ~wr_n & (full_flag != fw);
  assign rd_ok = ~rd_n & ~rd_sel_n & (empty_flag != fw);
  assign push  = wr_ok;
  assign pop   = fw ? ((mcount != '0) & (~valid | rd_ok)) : rd_ok;

  assign lvl_next = LW'(mcount) + LW'(push) - LW'(pop) + LW'(valid_next);
  assign lvl_now  = LW'(mcount) + LW'(valid);

  ffq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata (wr_data),
    .pop   (pop),
    .rdata (mem_word),
    .count (mcount)
  );

  ffq_outreg #(.WIDTH(WIDTH)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .fw         (fw),
    .pop        (pop),
    .rd_ok      (rd_ok),
    .din        (mem_word),
    .dout       (rd_data),
    .valid      (valid),
    .valid_next (valid_next)
  );

  ffq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk            (clk),
    .rst_n          (rst_n),
    .fwft_sel       (fwft_sel),
    .fw             (fw),
    .lvl_next       (lvl_next),
    .af_ofs         (af_ofs),
    .ae_ofs         (ae_ofs),
    .rd_ok          (rd_ok),
    .valid_next     (valid_next),
    .full_flag      (full_flag),
    .empty_flag     (empty_flag),
    .almost_full_n  (almost_full_n),
    .almost_empty_n (almost_empty_n),
    .half_full_n    (half_full_n),
    .echo_rd_n      (echo_rd_n)
  );
endmodule

// File: rtl/ffq_checker.sv
`timescale 1ns/1ps
module ffq_checker #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fw,
  input logic             wr_n,
  input logic             rd_n,
  input logic             rd_sel_n,
  input logic [WIDTH-1:0] rd_data,
  input logic             full_flag,
  input logic             empty_flag,
  input logic             echo_rd_n,
  input logic [LW-1:0]    lvl
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lvl) <= (DEPTH + (fw ? 1 : 0))); // R2

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fw && !full_flag && (rd_n || rd_sel_n)) |=> !full_flag); // R2

  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fw && !empty_flag && wr_n) |=> (!empty_flag && $stable(rd_data))); // R3

  AST_IR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fw && full_flag && (rd_n || rd_sel_n)) |=> full_flag); // R4

  AST_OR_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (fw && !empty_flag && (rd_n || rd_sel_n)) |=> (!empty_flag && $stable(rd_data))); // R6

  AST_ECHO_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !echo_rd_n |-> $past(!rd_n && !rd_sel_n)); // R10

  AST_WR_ONLY_NO_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && !wr_n) |=> echo_rd_n); // R10
endmodule

bind ffq_dualmode_fifo ffq_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fw         (fw),
  .wr_n       (wr_n),
  .rd_n       (rd_n),
  .rd_sel_n   (rd_sel_n),
  .rd_data    (rd_data),
  .full_flag  (full_flag),
  .empty_flag (empty_flag),
  .echo_rd_n  (echo_rd_n),
  .lvl        (lvl_now)
);

// File: tb/ffq_dualmode_fifo_test.sv
`timescale 1ns/1ps
module ffq_dualmode_fifo_test;
  localparam int W  = 8;
  localparam int D  = 8;
  localparam int LW = $clog2(D + 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fwft_sel = 1'b0;
  logic          wr_n = 1'b1, rd_n = 1'b1, rd_sel_n = 1'b1;
  logic [W-1:0]  wr_data = '0;
  logic [LW-1:0] af_ofs = '0, ae_ofs = '0;
  logic [W-1:0]  rd_data;
  logic          full_flag, empty_flag, almost_full_n, almost_empty_n, half_full_n, echo_rd_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ffq_dualmode_fifo #(.WIDTH(W), .DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .fwft_sel(fwft_sel), .wr_n(wr_n), .wr_data(wr_data),
    .rd_n(rd_n), .rd_sel_n(rd_sel_n), .af_ofs(af_ofs), .ae_ofs(ae_ofs),
    .rd_data(rd_data), .full_flag(full_flag), .empty_flag(empty_flag),
    .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n),
    .half_full_n(half_full_n), .echo_rd_n(echo_rd_n)
  );

  // behavioural reference: queue of stored words plus presented word
  logic [W-1:0] mq [$];
  logic [W-1:0] mdout;
  bit mmode, mov, mdv;
  bit m_full, m_empty, m_af, m_ae, m_hf, m_echo;

  always @(posedge clk) begin
    if (!rst_n) begin
      mmode = fwft_sel; mq.delete(); mov = 0; mdv = 0;
      m_full = !fwft_sel; m_empty = fwft_sel;
      m_af = 1; m_ae = 0; m_hf = 1; m_echo = 1;
    end else begin : mdl
      bit wok, rok;
      int lvl, cap, extra;
      wok = !wr_n && (mmode ? !m_full : m_full);
      rok = !rd_n && !rd_sel_n && (mmode ? !m_empty : m_empty);
      if (!mmode) begin
        if (rok) begin mdout = mq.pop_front(); mdv = 1; end
      end else begin
        if (mq.size() > 0 && (!mov || rok)) begin
          mdout = mq.pop_front(); mov = 1; mdv = 1;
        end else if (rok) mov = 0;
      end
      if (wok) mq.push_back(wr_data);
      extra = mmode ? 1 : 0;
      lvl = mq.size() + (mmode && mov ? 1 : 0);
      cap = D + extra;
      m_full  = mmode ? (lvl == cap) : (lvl != D);
      m_empty = mmode ? !mov : (lvl != 0);
      m_af = !(lvl >= cap - int'(af_ofs));
      m_ae = !(lvl <= int'(ae_ofs) + extra);
      m_hf = !(lvl > D / 2 + extra);
      m_echo = !rok;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(mmode ? "R4" : "R2", "full_flag", full_flag, m_full);
    chk(mmode ? "R5" : "R3", "empty_flag", empty_flag, m_empty);
    chk("R7", "almost_full_n", almost_full_n, m_af);
    chk("R8", "almost_empty_n", almost_empty_n, m_ae);
    chk("R9", "half_full_n", half_full_n, m_hf);
    chk("R10", "echo_rd_n", echo_rd_n, m_echo);
    if (mdv) chk("R12", "rd_data", rd_data, mdout);
  endtask

  logic [W-1:0] seq = 8'h10;

  task automatic step(input bit w, input bit r, input bit s);
    wr_n = !w; wr_data = seq; rd_n = !r; rd_sel_n = !s;
    if (w) seq = seq + 8'd1;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset(input bit m, input int mo, input int no);
    @(negedge clk);
    rst_n = 0; fwft_sel = m; wr_n = 1; rd_n = 1; rd_sel_n = 1;
    af_ofs = LW'(mo); ae_ofs = LW'(no);
    repeat (2) @(negedge clk);
    rst_n = 1;
    fwft_sel = !m; // mode must stay latched (R1)
    // R1: values right after reset
    chk("R1", "full_flag", full_flag, m ? 0 : 1);
    chk("R1", "empty_flag", empty_flag, m ? 1 : 0);
    chk("R1", "almost_full_n", almost_full_n, 1);
    chk("R1", "almost_empty_n", almost_empty_n, 0);
    chk("R1", "half_full_n", half_full_n, 1);
    chk("R1", "echo_rd_n", echo_rd_n, 1);
  endtask

  task automatic run_mode(input bit m, input int mo, input int no);
    logic [15:0] lf = 16'hACE1;
    logic [W-1:0] first, last;
    do_reset(m, mo, no);
    first = seq;
    step(1, 0, 0);
    // R11: select held inactive; FWFT word still falls through
    step(0, 1, 0);
    if (m) begin
      chk("R5", "empty_flag after fall-through", empty_flag, 0);
      chk("R11", "rd_data after fall-through", rd_data, first);
    end else begin
      chk("R11", "empty_flag unaffected by select", empty_flag, 1);
    end
    // fill with select off: reads ignored, extra writes blocked
    for (int i = 0; i < D + 3; i++) step(1, 1, 0);
    if (m) chk("R4", "input-ready after D+1 words", full_flag, 1);
    else   chk("R2", "full after D words", full_flag, 0);
    // drain and over-read
    for (int i = 0; i < D + 4; i++) begin
      if (i == D - 1 + (m ? 1 : 0)) last = rd_data;
      step(0, 1, 1);
    end
    if (m) chk("R6", "output-ready after last read", empty_flag, 1);
    else   chk("R3", "empty after drain", empty_flag, 0);
    chk("R12", "no extra word after drain", int'(mq.size()), 0);
    last = rd_data;
    step(0, 1, 1);
    chk(m ? "R6" : "R3", "data held on blocked read", rd_data, last);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (i < 200) step(lf[0] | lf[1], lf[2] & lf[3], lf[4] | lf[5]);
      else         step(lf[0] & lf[1], lf[2] | lf[3], lf[4] | lf[5] | lf[6]);
    end
  endtask

  initial begin
    #(150000 * 10);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    run_mode(0, 3, 2);
    run_mode(1, 3, 2);
    run_mode(0, 0, 5);
    run_mode(1, 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule